// File: doc/BRIEF.md
# Watchdog Frequency Recovery Controller

This block decides which divider settings a clock synthesizer falls back to once a watchdog expires after a failed overclock. It keeps three possible sources of settings: the power-on values taken from the frequency-select straps, a copy of the running settings taken when the watchdog is armed, and an N value written by software that is paired with an M copy software cannot see.

On each timeout event the block looks at its mode bits. It then either leaves the synthesizer alone, because a reset is all that was asked for or no valid copy exists, or it presents a set of M, N and O values together with a one-cycle load strobe. The watchdog counter, the reset pulse generator, the synthesizer and the register bus decoding sit outside this block.

Top module: `wdrec_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `load_stb` is 0 and `load_m`, `load_n` and `load_o` are all 0.
- R2: `load_stb` is high for exactly one cycle per accepted timeout, in the cycle after `expire` was sampled high. It is never high without a timeout.
- R3: When `cfg_reset_only` is 1, a timeout gives no strobe and the load outputs keep their values.
- R4: When `cfg_reset_only` is 0 and `cfg_src_regs` is 0, a timeout loads the strap M, N and O values that were captured most recently.
- R5: `strap_capture` samples the strap inputs. Changes on the strap inputs at any other time do not affect what a later hardware-source timeout loads.
- R6: When `cfg_auto` is 1, `arm_rise` copies `cur_m` and `cur_n` into the recovery registers. A timeout with `cfg_src_regs` at 1 then loads those copies, with O taken from `cur_o` in the timeout cycle.
- R7: When `cfg_auto` is 0, `usr_n_we` stores `usr_n_wdata` as the N recovery value, and `arm_rise` copies only `cur_m`. A timeout with `cfg_src_regs` at 1 loads the latched M and the software N.
- R8: While `cfg_auto` is 1, N recovery writes are ignored.
- R9: If `arm_rise` and `usr_n_we` occur in the same cycle, the write is dropped.
- R10: If `cfg_src_regs` is 1 and either the M copy or the N copy has never been filled since reset, a timeout gives no strobe and the outputs hold.
- R11: While `load_stb` is low, `load_m`, `load_n` and `load_o` do not change.
- R12: The full 9-bit N range, including 511, passes through the N recovery register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_m | input | 9 | M value from the frequency-select straps |
| strap_n | input | 9 | N value from the frequency-select straps |
| strap_o | input | 4 | O value from the frequency-select straps |
| strap_capture | input | 1 | Boot-time pulse that samples the strap values |
| cur_m | input | 9 | M value the synthesizer is running with now |
| cur_n | input | 9 | N value the synthesizer is running with now |
| cur_o | input | 4 | O value the synthesizer is running with now |
| arm_rise | input | 1 | Watchdog enable went from 0 to 1 (one-cycle event) |
| expire | input | 1 | Watchdog timeout (one-cycle event) |
| cfg_reset_only | input | 1 | 1: timeout resets only; 0: reset plus frequency recovery |
| cfg_src_regs | input | 1 | 1: recover from the recovery registers; 0: recover from the straps |
| cfg_auto | input | 1 | 1: N is copied automatically; 0: software writes N |
| usr_n_we | input | 1 | Write strobe for the N recovery register |
| usr_n_wdata | input | 9 | Write data for the N recovery register |
| load_stb | output | 1 | One-cycle load request to the synthesizer |
| load_m | output | 9 | M value to load |
| load_n | output | 9 | N value to load |
| load_o | output | 4 | O value to load |

## Verification
The bench builds the block with its default widths: 9-bit M and N and 4-bit O. At these widths the bench can reach the all-ones N code of 511 and can tell apart strap, snapshot and software values that differ in every field. It walks through the three recovery sources, the reset-only mode and the empty-register case in one sequence. In this sequence each new mode follows a state left behind by the previous one, so stale copies and dropped writes show up as wrong loaded values.

// File: rtl/wdrec_pkg.sv
package wdrec_pkg;
  parameter int unsigned WDR_M_W = 9;
  parameter int unsigned WDR_N_W = 9;
  parameter int unsigned WDR_O_W = 4;

  typedef struct packed {
    logic [WDR_M_W-1:0] m;
    logic [WDR_N_W-1:0] n;
    logic [WDR_O_W-1:0] o;
  } wdr_freq_t;

  typedef enum logic [1:0] {
    SEL_HOLD  = 2'd0,
    SEL_STRAP = 2'd1,
    SEL_COPY  = 2'd2
  } wdr_sel_e;
endpackage

// File: rtl/wdrec_strap.sv
module wdrec_strap
  import wdrec_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      capture,
  input  wdr_freq_t strap,
  output wdr_freq_t hw
);
  wdr_freq_t hw_q, hw_d;

  always_comb begin
    hw_d = hw_q;
    if (capture) hw_d = strap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hw_q <= '0;
    else        hw_q <= hw_d;
  end

  assign hw = hw_q;
endmodule

// File: rtl/wdrec_snap.sv
module wdrec_snap
  import wdrec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm_rise,
  input  logic               cfg_auto,
  input  logic               usr_we,
  input  logic [WDR_N_W-1:0] usr_n,
  input  logic [WDR_M_W-1:0] cur_m,
  input  logic [WDR_N_W-1:0] cur_n,
  output logic [WDR_M_W-1:0] rec_m,
  output logic [WDR_N_W-1:0] rec_n,
  output logic               rec_ok
);
  logic [WDR_M_W-1:0] rec_m_q, rec_m_d;
  logic [WDR_N_W-1:0] rec_n_q, rec_n_d;
  logic               m_vld_q, m_vld_d;
  logic               n_vld_q, n_vld_d;
  logic               copy_n, take_usr;

  always_comb begin
    copy_n   = arm_rise & cfg_auto;
    take_usr = usr_we & ~cfg_auto & ~arm_rise;
    rec_m_d  = rec_m_q;
    rec_n_d  = rec_n_q;
    if (arm_rise) rec_m_d = cur_m;
    if (copy_n)        rec_n_d = cur_n;
    else if (take_usr) rec_n_d = usr_n;
    m_vld_d = m_vld_q | arm_rise;
    n_vld_d = n_vld_q | copy_n | take_usr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_m_q <= '0;
      rec_n_q <= '0;
      m_vld_q <= 1'b0;
      n_vld_q <= 1'b0;
    end else begin
      rec_m_q <= rec_m_d;
      rec_n_q <= rec_n_d;
      m_vld_q <= m_vld_d;
      n_vld_q <= n_vld_d;
    end
  end

  assign rec_m  = rec_m_q;
  assign rec_n  = rec_n_q;
  assign rec_ok = m_vld_q & n_vld_q;

  p_snap_m_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm_rise) |-> rec_m_q == $past(cur_m));
  p_user_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_auto) && !$past(arm_rise) |-> $stable(rec_n_q));
  p_clash_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(arm_rise) && !$past(cfg_auto) |-> $stable(rec_n_q));
endmodule

// File: rtl/wdrec_select.sv
module wdrec_select
  import wdrec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               expire,
  input  logic               cfg_reset_only,
  input  logic               cfg_src_regs,
  input  wdr_freq_t          hw,
  input  logic [WDR_M_W-1:0] rec_m,
  input  logic [WDR_N_W-1:0] rec_n,
  input  logic               rec_ok,
  input  logic [WDR_O_W-1:0] cur_o,
  output logic               stb,
  output wdr_freq_t          out
);
  wdr_sel_e  sel;
  wdr_freq_t out_q, out_d;
  logic      stb_q, stb_d;

  always_comb begin
    sel = SEL_HOLD;
    if (expire && !cfg_reset_only) begin
      if (!cfg_src_regs) sel = SEL_STRAP;
      else if (rec_ok)   sel = SEL_COPY;
    end
  end

  always_comb begin
    out_d = out_q;
    unique case (sel)
      SEL_STRAP: out_d = hw;
      SEL_COPY:  out_d = '{m: rec_m, n: rec_n, o: cur_o};
      default:   out_d = out_q;
    endcase
    stb_d = (sel != SEL_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      stb_q <= 1'b0;
    end else begin
      stb_q <= stb_d;
      if (stb_d) out_q <= out_d;
    end
  end

  assign stb = stb_q;
  assign out = out_q;

  p_strobe_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q |-> $past(expire) && !$past(cfg_reset_only));
  p_reset_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(expire) && $past(cfg_reset_only) |-> !stb_q);
  p_hw_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stb_q && !$past(cfg_src_regs) |-> out_q == $past(hw));
  p_empty_copy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_src_regs) && !$past(rec_ok) |-> !stb_q);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_q |-> $stable(out_q));
endmodule

// File: rtl/wdrec_ctrl.sv
module wdrec_ctrl
  import wdrec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [WDR_M_W-1:0] strap_m,
  input  logic [WDR_N_W-1:0] strap_n,
  input  logic [WDR_O_W-1:0] strap_o,
  input  logic               strap_capture,
  input  logic [WDR_M_W-1:0] cur_m,
  input  logic [WDR_N_W-1:0] cur_n,
  input  logic [WDR_O_W-1:0] cur_o,
  input  logic               arm_rise,
  input  logic               expire,
  input  logic               cfg_reset_only,
  input  logic               cfg_src_regs,
  input  logic               cfg_auto,
  input  logic               usr_n_we,
  input  logic [WDR_N_W-1:0] usr_n_wdata,
  output logic               load_stb,
  output logic [WDR_M_W-1:0] load_m,
  output logic [WDR_N_W-1:0] load_n,
  output logic [WDR_O_W-1:0] load_o
);
  wdr_freq_t          strap_v, hw_v, out_v;
  logic [WDR_M_W-1:0] rec_m;
  logic [WDR_N_W-1:0] rec_n;
  logic               rec_ok;

  assign strap_v = '{m: strap_m, n: strap_n, o: strap_o};

  wdrec_strap u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (strap_capture),
    .strap   (strap_v),
    .hw      (hw_v)
  );

  wdrec_snap u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .arm_rise (arm_rise),
    .cfg_auto (cfg_auto),
    .usr_we   (usr_n_we),
    .usr_n    (usr_n_wdata),
    .cur_m    (cur_m),
    .cur_n    (cur_n),
    .rec_m    (rec_m),
    .rec_n    (rec_n),
    .rec_ok   (rec_ok)
  );

  wdrec_select u_sel (
    .clk            (clk),
    .rst_n          (rst_n),
    .expire         (expire),
    .cfg_reset_only (cfg_reset_only),
    .cfg_src_regs   (cfg_src_regs),
    .hw             (hw_v),
    .rec_m          (rec_m),
    .rec_n          (rec_n),
    .rec_ok         (rec_ok),
    .cur_o          (cur_o),
    .stb            (load_stb),
    .out            (out_v)
  );

  assign load_m = out_v.m;
  assign load_n = out_v.n;
  assign load_o = out_v.o;
endmodule

// File: tb/wdrec_ctrl_test.sv
module wdrec_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [8:0] strap_m, strap_n, cur_m, cur_n, usr_n_wdata;
  logic [3:0] strap_o, cur_o;
  logic       strap_capture, arm_rise, expire;
  logic       cfg_reset_only, cfg_src_regs, cfg_auto, usr_n_we;
  logic       load_stb;
  logic [8:0] load_m, load_n;
  logic [3:0] load_o;

  int checks = 0;
  int fails  = 0;
  logic [21:0] exp_q[$];
  string       tag_q[$];
  logic [21:0] last_out = '0;

  always #4 clk = ~clk;

  wdrec_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .strap_m(strap_m), .strap_n(strap_n), .strap_o(strap_o),
    .strap_capture(strap_capture),
    .cur_m(cur_m), .cur_n(cur_n), .cur_o(cur_o),
    .arm_rise(arm_rise), .expire(expire),
    .cfg_reset_only(cfg_reset_only), .cfg_src_regs(cfg_src_regs),
    .cfg_auto(cfg_auto), .usr_n_we(usr_n_we), .usr_n_wdata(usr_n_wdata),
    .load_stb(load_stb), .load_m(load_m), .load_n(load_n), .load_o(load_o)
  );

  function automatic logic [21:0] pack(input int m, input int n, input int o);
    return {9'(m), 9'(n), 4'(o)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected loads as strobes appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && load_stb === 1'b1) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected strobe", 32'(load_stb), 32'd0);
      end else begin
        automatic logic [21:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 32'({load_m, load_n, load_o}), 32'(e));
      end
      last_out = {load_m, load_n, load_o};
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic timeout(input bit strobe, input logic [21:0] e, input string req);
    if (strobe) begin
      exp_q.push_back(e);
      tag_q.push_back(req);
    end
    expire = 1'b1;
    tick();
    expire = 1'b0;
    if (!strobe) begin
      check({req, " no strobe"}, 32'(load_stb), 32'd0);
      check({req, " outputs held R11"}, 32'({load_m, load_n, load_o}), 32'(last_out));
    end
    tick();
    tick();
    check("R2 single-cycle strobe", 32'(load_stb), 32'd0);
  endtask

  task automatic arm();
    arm_rise = 1'b1; tick(); arm_rise = 1'b0;
  endtask

  task automatic wr_n(input int v);
    usr_n_we = 1'b1; usr_n_wdata = 9'(v); tick(); usr_n_we = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    strap_m = '0; strap_n = '0; strap_o = '0; strap_capture = 1'b0;
    cur_m = '0; cur_n = '0; cur_o = '0; arm_rise = 1'b0; expire = 1'b0;
    cfg_reset_only = 1'b0; cfg_src_regs = 1'b0; cfg_auto = 1'b1;
    usr_n_we = 1'b0; usr_n_wdata = '0;
    tick(); tick();
    check("R1 strobe in reset", 32'(load_stb), 32'd0);
    rst_n = 1'b1;
    tick();
    check("R1 strobe after reset", 32'(load_stb), 32'd0);
    check("R1 outputs after reset", 32'({load_m, load_n, load_o}), 32'd0);

    // R5: capture straps, then disturb the strap pins
    strap_m = 9'd100; strap_n = 9'd200; strap_o = 4'd5;
    strap_capture = 1'b1; tick(); strap_capture = 1'b0;
    strap_m = 9'd7; strap_n = 9'd8; strap_o = 4'd9;
    tick();
    timeout(1'b1, pack(100, 200, 5), "R4 R5 strap reload");

    // R3: reset-only mode
    cfg_reset_only = 1'b1;
    timeout(1'b0, '0, "R3 reset only");
    cfg_reset_only = 1'b0;

    // R10: register source with empty copies
    cfg_src_regs = 1'b1;
    timeout(1'b0, '0, "R10 empty copy");

    // R6: automatic copy on arm
    cur_m = 9'd300; cur_n = 9'd411; cur_o = 4'd9;
    arm();
    cur_m = 9'd1; cur_n = 9'd2; cur_o = 4'd3;
    tick();
    timeout(1'b1, pack(300, 411, 3), "R6 auto copy");

    // R8: writes ignored in auto mode
    wr_n(77);
    tick();
    timeout(1'b1, pack(300, 411, 3), "R8 write ignored");

    // R7: manual mode
    cfg_auto = 1'b0;
    wr_n(55);
    cur_m = 9'd123; cur_n = 9'd400;
    arm();
    tick();
    timeout(1'b1, pack(123, 55, 3), "R7 manual N");

    // R9: arm and write collide
    cur_m = 9'd45;
    arm_rise = 1'b1; usr_n_we = 1'b1; usr_n_wdata = 9'd99;
    tick();
    arm_rise = 1'b0; usr_n_we = 1'b0;
    tick();
    timeout(1'b1, pack(45, 55, 3), "R9 snapshot wins");

    // R12: full-range N
    wr_n(511);
    cur_o = 4'd15;
    tick();
    timeout(1'b1, pack(45, 511, 15), "R12 N max");

    // R4 again from straps after register use
    cfg_src_regs = 1'b0;
    timeout(1'b1, pack(100, 200, 5), "R4 strap after copies");

    tick(); tick();
    check("R2 all expected strobes seen", 32'(exp_q.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule